// File: doc/BRIEF.md
# Dual-Channel DMA Control Register Block

This block is the software-visible control plane for a pair of DMA channels, one serving a SCSI controller and one serving an Ethernet controller. A processor reaches it through a plain word-addressed register bus with separate read and write strobes. Eight 32-bit registers sit behind that bus. Three of them carry behaviour: a control/status word for each channel and a transfer address for the SCSI channel. The other five hold whatever software writes, and one of them serves as the network channel's base register.

Each channel drives its own interrupt output and a one-clock reset strobe towards its peripheral. The SCSI side also works with the transfer engine. That engine reports each completed transfer and its byte count, and the block then advances the stored address and flags the completion. The engine and the peripherals are outside this block. Only the register state and the sideband strobes live here.

Top module: `dual_dma_csr`

## Requirements
- R1: A register is chosen by byte-address bits [4:2]: 0 is SCSI control, 1 is SCSI address, 4 is network control, and the rest are plain. Address bits [1:0] and all bits above bit 4 have no effect.
- R2: After reset, SCSI control and network control read 0xA0000000, every other register reads zero, and all four sideband outputs are low.
- R3: A write to SCSI control or network control stores 0xA in bits [31:28]. Bits [27:0] come from the written word, subject only to the bit-6 rule of R6.
- R4: A SCSI control write with bit 4 (interrupt enable) clear drops `scsi_irq` on the next clock. A write with bit 4 set leaves `scsi_irq` as it was.
- R5: A SCSI control write with bit 7 set raises `scsi_rst_pulse` for exactly one clock, and bit 7 is stored as written.
- R6: For a SCSI control write with bit 7 clear, a set bit 6 is stored as 0. If the whole written word is zero, bit 6 is stored as 1, so the register reads 0xA0000040. Network control writes store bit 6 unchanged.
- R7: A network control write with bit 7 set raises `net_rst_pulse` for exactly one clock. A write with bit 4 clear drops `net_irq`. `net_irq_raise` sets `net_irq`, and in a conflict it wins over a write that would drop it.
- R8: Any write to the SCSI address register sets bit 26 (loaded) of SCSI control and leaves its other bits unchanged.
- R9: A `scsi_xfer_done` strobe adds `scsi_xfer_len` to the SCSI address, wrapping modulo 2^32, and sets bit 0 of SCSI control without changing `scsi_irq`. A bus write to the address register in the same cycle takes precedence over the increment.
- R10: `scsi_irq_raise` sets bit 0 of SCSI control and asserts `scsi_irq`. `scsi_irq_clear` clears both. When the two arrive together, clear wins.
- R11: Plain registers store the written word unchanged. Reads change no state. `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| scsi_irq_raise | input | 1 | SCSI peripheral requests an interrupt |
| scsi_irq_clear | input | 1 | SCSI peripheral withdraws its interrupt |
| scsi_xfer_done | input | 1 | SCSI transfer finished |
| scsi_xfer_len | input | LEN_W | Bytes moved by the finished transfer |
| net_irq_raise | input | 1 | Network peripheral requests an interrupt |
| scsi_irq | output | 1 | SCSI channel interrupt |
| net_irq | output | 1 | Network channel interrupt |
| scsi_rst_pulse | output | 1 | One-clock reset strobe to the SCSI peripheral |
| net_rst_pulse | output | 1 | One-clock reset strobe to the network peripheral |

## Verification
The bench targets the bit-6 rule. A design that applied it to network control, or that missed the all-zero case, would read back 0xA0000000 where 0xA0000040 is expected, or the reverse. It also targets the SCSI address update: it checks the 32-bit wrap after an increment, and a bus write landing in the same cycle as a completion. A design that gave the increment priority, or truncated the adder, would read back the wrong address.

The bench checks that a completion sets the flag bit while leaving the interrupt line low. It also drives same-cycle conflicts between raise and clear, and between a raise and a disabling write. A wrong priority order would leave an interrupt line in the opposite state. Finally, it decodes aliased addresses with high and low bits set, which exposes a decoder that uses too many address bits.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_REGS  = 8;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int BYTE_OFS  = 2;

    // register slots whose behaviour is wired to this block
    localparam int IDX_SCSI_CTL  = 0;
    localparam int IDX_SCSI_ADDR = 1;
    localparam int IDX_NET_CTL   = 4;

    // control word bit positions
    localparam int BIT_IRQ_FLAG = 0;
    localparam int BIT_IRQ_EN   = 4;
    localparam int BIT_QUIRK    = 6;
    localparam int BIT_CHAN_RST = 7;
    localparam int BIT_LOADED   = 26;

    localparam int           VER_LSB  = 28;
    localparam logic [3:0]   VER_CODE = 4'hA;

    typedef logic [DATA_W-1:0] word_t;

    localparam word_t CTL_RESET = {VER_CODE, {VER_LSB{1'b0}}};

    function automatic word_t stamp_version(word_t raw);
        return {VER_CODE, raw[VER_LSB-1:0]};
    endfunction

    function automatic logic is_plain_slot(int idx);
        return (idx != IDX_SCSI_CTL) && (idx != IDX_SCSI_ADDR) && (idx != IDX_NET_CTL);
    endfunction

    typedef struct packed {
        word_t ctl;
        word_t addr;
        logic  irq;
        logic  rst_pulse;
    } scsi_state_t;

    typedef struct packed {
        word_t ctl;
        logic  irq;
        logic  rst_pulse;
    } net_state_t;

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [SEL_W-1:0]    reg_sel
);

    localparam int SEL_LSB = BYTE_OFS;
    localparam int SEL_MSB = BYTE_OFS + SEL_W - 1;

    assign reg_sel = bus_addr[SEL_MSB:SEL_LSB];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
            assign wr_hit[g] = bus_wr && (reg_sel == SEL_W'(g));
        end
        if (ADDR_W > SEL_MSB + 1) begin : g_high
            logic unused_high;
            assign unused_high = ^bus_addr[ADDR_W-1:SEL_MSB+1];
        end
    endgenerate

    logic unused_low;
    assign unused_low = ^bus_addr[SEL_LSB-1:0];

endmodule

// File: rtl/dma_scsi_chan.sv
module dma_scsi_chan
    import dma_csr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_addr,
    input  word_t            wdata,
    input  logic             irq_raise,
    input  logic             irq_clear,
    input  logic             xfer_done,
    input  logic [LEN_W-1:0] xfer_len,
    output word_t            ctl,
    output word_t            addr,
    output logic             irq,
    output logic             rst_pulse
);

    scsi_state_t st_d, st_q;
    word_t       ctl_val;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        ctl_val        = wdata;

        // bus write to the control word
        if (wr_ctl) begin
            if (wdata[BIT_CHAN_RST]) begin
                st_d.rst_pulse = 1'b1;
            end else if (wdata[BIT_QUIRK]) begin
                ctl_val[BIT_QUIRK] = 1'b0;
            end else if (wdata == '0) begin
                ctl_val[BIT_QUIRK] = 1'b1;
            end
            st_d.ctl = stamp_version(ctl_val);
            if (!wdata[BIT_IRQ_EN]) begin
                st_d.irq = 1'b0;
            end
        end

        // address register: bus write beats completion increment
        if (wr_addr) begin
            st_d.addr            = wdata;
            st_d.ctl[BIT_LOADED] = 1'b1;
        end else if (xfer_done) begin
            st_d.addr = st_q.addr + DATA_W'(xfer_len);
        end

        if (xfer_done) begin
            st_d.ctl[BIT_IRQ_FLAG] = 1'b1;
        end

        // peripheral interrupt events, clear applied last
        if (irq_raise) begin
            st_d.ctl[BIT_IRQ_FLAG] = 1'b1;
            st_d.irq               = 1'b1;
        end
        if (irq_clear) begin
            st_d.ctl[BIT_IRQ_FLAG] = 1'b0;
            st_d.irq               = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl       <= CTL_RESET;
            st_q.addr      <= '0;
            st_q.irq       <= 1'b0;
            st_q.rst_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl       = st_q.ctl;
    assign addr      = st_q.addr;
    assign irq       = st_q.irq;
    assign rst_pulse = st_q.rst_pulse;

endmodule

// File: rtl/dma_net_chan.sv
module dma_net_chan
    import dma_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ctl,
    input  word_t wdata,
    input  logic  irq_raise,
    output word_t ctl,
    output logic  irq,
    output logic  rst_pulse
);

    net_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;

        if (wr_ctl) begin
            st_d.ctl       = stamp_version(wdata);
            st_d.rst_pulse = wdata[BIT_CHAN_RST];
            if (!wdata[BIT_IRQ_EN]) begin
                st_d.irq = 1'b0;
            end
        end

        // a fresh request outranks a disabling write
        if (irq_raise) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl       <= CTL_RESET;
            st_q.irq       <= 1'b0;
            st_q.rst_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl       = st_q.ctl;
    assign irq       = st_q.irq;
    assign rst_pulse = st_q.rst_pulse;

endmodule

// File: rtl/dma_csr_store.sv
module dma_csr_store
    import dma_csr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGS-1:0]            wr_hit,
    input  word_t                          wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] slots
);

    logic [NUM_REGS-1:0][DATA_W-1:0] slots_d, slots_q;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
            if (is_plain_slot(g)) begin : g_plain
                always_comb begin
                    slots_d[g] = wr_hit[g] ? wdata : slots_q[g];
                end
            end else begin : g_owned
                logic unused_hit;
                assign unused_hit = wr_hit[g];
                always_comb begin
                    slots_d[g] = '0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    assign slots = slots_q;

endmodule

// File: rtl/dual_dma_csr.sv
module dual_dma_csr
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              scsi_irq_raise,
    input  logic              scsi_irq_clear,
    input  logic              scsi_xfer_done,
    input  logic [LEN_W-1:0]  scsi_xfer_len,
    input  logic              net_irq_raise,
    output logic              scsi_irq,
    output logic              net_irq,
    output logic              scsi_rst_pulse,
    output logic              net_rst_pulse
);

    logic [NUM_REGS-1:0]             wr_hit;
    logic [SEL_W-1:0]                reg_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] plain_slots;
    word_t                           scsi_ctl, scsi_addr, net_ctl;

    dma_csr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .wr_hit   (wr_hit),
        .reg_sel  (reg_sel)
    );

    dma_scsi_chan #(
        .LEN_W (LEN_W)
    ) u_scsi (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_hit[IDX_SCSI_CTL]),
        .wr_addr   (wr_hit[IDX_SCSI_ADDR]),
        .wdata     (bus_wdata),
        .irq_raise (scsi_irq_raise),
        .irq_clear (scsi_irq_clear),
        .xfer_done (scsi_xfer_done),
        .xfer_len  (scsi_xfer_len),
        .ctl       (scsi_ctl),
        .addr      (scsi_addr),
        .irq       (scsi_irq),
        .rst_pulse (scsi_rst_pulse)
    );

    dma_net_chan u_net (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_hit[IDX_NET_CTL]),
        .wdata     (bus_wdata),
        .irq_raise (net_irq_raise),
        .ctl       (net_ctl),
        .irq       (net_irq),
        .rst_pulse (net_rst_pulse)
    );

    dma_csr_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (bus_wdata),
        .slots  (plain_slots)
    );

    // read mux: pure selection, no state touched
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (int'(reg_sel))
                IDX_SCSI_CTL:  bus_rdata = scsi_ctl;
                IDX_SCSI_ADDR: bus_rdata = scsi_addr;
                IDX_NET_CTL:   bus_rdata = net_ctl;
                default:       bus_rdata = plain_slots[reg_sel];
            endcase
        end
    end

endmodule

// File: rtl/dual_dma_csr_chk.sv
module dual_dma_csr_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              scsi_irq_raise,
    input logic              scsi_irq_clear,
    input logic              scsi_xfer_done,
    input logic              net_irq_raise,
    input logic              scsi_irq,
    input logic              net_irq,
    input logic              scsi_rst_pulse,
    input logic              net_rst_pulse
);

    logic [2:0] sel;
    logic       wr_scsi_ctl, wr_net_ctl;

    assign sel         = bus_addr[4:2];
    assign wr_scsi_ctl = bus_wr && (sel == 3'd0);
    assign wr_net_ctl  = bus_wr && (sel == 3'd4);

    AST_VERSION_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == 3'd0 || sel == 3'd4)) |-> (bus_rdata[31:28] == 4'hA)); // R3

    AST_SCSI_RST_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_scsi_ctl && bus_wdata[7]) |=> scsi_rst_pulse); // R5

    AST_SCSI_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_rst_pulse |-> $past(wr_scsi_ctl && bus_wdata[7])); // R5

    AST_NET_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        net_rst_pulse |-> $past(wr_net_ctl && bus_wdata[7])); // R7

    AST_RST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(scsi_rst_pulse && net_rst_pulse)); // R5

    AST_SCSI_IRQ_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_scsi_ctl && !bus_wdata[4] && !scsi_irq_raise) |=> !scsi_irq); // R4

    AST_SCSI_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_irq_raise && !scsi_irq_clear) |=> scsi_irq); // R10

    AST_SCSI_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_irq_clear |=> !scsi_irq); // R10

    AST_DONE_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_xfer_done && !scsi_irq_raise && !scsi_irq_clear && !wr_scsi_ctl)
        |=> $stable(scsi_irq)); // R9

    AST_NET_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        net_irq_raise |=> net_irq); // R7

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 32'h0)); // R11

endmodule

bind dual_dma_csr dual_dma_csr_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_dual_dma_csr.sv
`timescale 1ns/1ps
module test_dual_dma_csr;

    localparam int ADDR_W = 8;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              scsi_irq_raise = 1'b0;
    logic              scsi_irq_clear = 1'b0;
    logic              scsi_xfer_done = 1'b0;
    logic [LEN_W-1:0]  scsi_xfer_len = '0;
    logic              net_irq_raise = 1'b0;
    logic              scsi_irq, net_irq, scsi_rst_pulse, net_rst_pulse;

    always #2.5 clk = ~clk;

    dual_dma_csr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_dual_dma_csr (.*);

    // kinds: 0 read data, 1 scsi_irq, 2 net_irq, 3 scsi reset strobe, 4 net reset strobe
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    // monitor: compares queued expectations mid-cycle
    initial begin
        item_t       it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                it = q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {31'b0, scsi_irq};
                    2:       act = {31'b0, net_irq};
                    3:       act = {31'b0, scsi_rst_pulse};
                    default: act = {31'b0, net_rst_pulse};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind %0d: actual 0x%08h expected 0x%08h",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_sig(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        expect_sig(0, e, tag);
        step();
        bus_rd   = 1'b0;
    endtask

    task automatic xfer(input logic [LEN_W-1:0] n);
        scsi_xfer_done = 1'b1;
        scsi_xfer_len  = n;
        step();
        scsi_xfer_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL ALL watchdog: actual 20000 cycles, expected completion earlier");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R2: reset state
        rd_chk(8'h00, 32'hA000_0000, "R2");
        rd_chk(8'h10, 32'hA000_0000, "R2");
        for (int i = 1; i < 8; i++) begin
            if (i != 4) rd_chk(8'(i * 4), 32'h0, "R2");
        end
        expect_sig(1, 0, "R2");
        expect_sig(2, 0, "R2");
        expect_sig(3, 0, "R2");
        expect_sig(4, 0, "R2");
        step();

        // R11: plain storage, side-effect-free reads, idle bus returns zero
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h1C, 32'h1234_5678);
        rd_chk(8'h08, 32'hDEAD_BEEF, "R11");
        rd_chk(8'h08, 32'hDEAD_BEEF, "R11");
        rd_chk(8'h1C, 32'h1234_5678, "R11");
        expect_sig(0, 32'h0, "R11");
        step();

        // R1: high and low address bits are ignored
        wr(8'hE8, 32'h0000_55AA);
        rd_chk(8'h08, 32'h0000_55AA, "R1");
        rd_chk(8'h0B, 32'h0000_55AA, "R1");
        wr(8'h37, 32'h0BAD_F00D);
        rd_chk(8'h14, 32'h0BAD_F00D, "R1");

        // R3: version stamp on both control words
        wr(8'h00, 32'h5123_4535);
        rd_chk(8'h00, 32'hA123_4535, "R3");
        wr(8'h10, 32'h0ABC_DE10);
        rd_chk(8'h10, 32'hAABC_DE10, "R3");

        // R6: bit-6 rule on the SCSI control word
        wr(8'h00, 32'h0000_0050);
        rd_chk(8'h00, 32'hA000_0010, "R6");
        wr(8'h00, 32'h0000_0000);
        rd_chk(8'h00, 32'hA000_0040, "R6");

        // R5: reset strobe, one clock, bit 7 kept
        wr(8'h00, 32'h0000_00C0);
        expect_sig(3, 1, "R5");
        expect_sig(4, 0, "R5");
        step();
        expect_sig(3, 0, "R5");
        rd_chk(8'h00, 32'hA000_00C0, "R5");

        // R8: loaded flag from an address write
        wr(8'h00, 32'h0000_0010);
        wr(8'h04, 32'h1000_0000);
        rd_chk(8'h00, 32'hA400_0010, "R8");
        rd_chk(8'h04, 32'h1000_0000, "R8");

        // R9: completion increments address, sets flag, irq unchanged
        xfer(16'h0200);
        rd_chk(8'h04, 32'h1000_0200, "R9");
        rd_chk(8'h00, 32'hA400_0011, "R9");
        expect_sig(1, 0, "R9");
        wr(8'h04, 32'hFFFF_FF00);
        xfer(16'h0180);
        rd_chk(8'h04, 32'h0000_0080, "R9");
        bus_addr       = 8'h04;
        bus_wdata      = 32'h0000_4000;
        bus_wr         = 1'b1;
        scsi_xfer_done = 1'b1;
        scsi_xfer_len  = 16'h0008;
        step();
        bus_wr         = 1'b0;
        scsi_xfer_done = 1'b0;
        rd_chk(8'h04, 32'h0000_4000, "R9");

        // R10: raise and clear of the SCSI interrupt
        wr(8'h00, 32'h0000_0010);
        scsi_irq_raise = 1'b1;
        step();
        scsi_irq_raise = 1'b0;
        expect_sig(1, 1, "R10");
        rd_chk(8'h00, 32'hA000_0011, "R10");
        scsi_irq_clear = 1'b1;
        step();
        scsi_irq_clear = 1'b0;
        expect_sig(1, 0, "R10");
        rd_chk(8'h00, 32'hA000_0010, "R10");
        scsi_irq_raise = 1'b1;
        scsi_irq_clear = 1'b1;
        step();
        scsi_irq_raise = 1'b0;
        scsi_irq_clear = 1'b0;
        expect_sig(1, 0, "R10");
        rd_chk(8'h00, 32'hA000_0010, "R10");

        // R4: enable bit governs whether a control write drops the line
        scsi_irq_raise = 1'b1;
        step();
        scsi_irq_raise = 1'b0;
        wr(8'h00, 32'h0000_0011);
        expect_sig(1, 1, "R4");
        step();
        wr(8'h00, 32'h0000_0001);
        expect_sig(1, 0, "R4");
        rd_chk(8'h00, 32'hA000_0001, "R4");

        // R7: network channel
        net_irq_raise = 1'b1;
        step();
        net_irq_raise = 1'b0;
        expect_sig(2, 1, "R7");
        wr(8'h10, 32'h0000_0010);
        expect_sig(2, 1, "R7");
        wr(8'h10, 32'h0000_0000);
        expect_sig(2, 0, "R7");
        rd_chk(8'h10, 32'hA000_0000, "R7");
        wr(8'h10, 32'h0000_0080);
        expect_sig(4, 1, "R7");
        expect_sig(3, 0, "R7");
        step();
        expect_sig(4, 0, "R7");
        rd_chk(8'h10, 32'hA000_0080, "R7");
        wr(8'h10, 32'h0000_0040);
        rd_chk(8'h10, 32'hA000_0040, "R6");
        bus_addr      = 8'h10;
        bus_wdata     = 32'h0;
        bus_wr        = 1'b1;
        net_irq_raise = 1'b1;
        step();
        bus_wr        = 1'b0;
        net_irq_raise = 1'b0;
        expect_sig(2, 1, "R7");
        step();
        step();

        done = 1;
        finish_run();
    end

endmodule